// File: doc/BRIEF.md
# Byte-Lane Masked Burst Write Slave

This block is a small memory-backed target for the write half of a five-channel on-chip bus. A master first presents a start address, a transaction ID and a burst length on the address channel. It then streams data beats on the data channel, and the final beat carries a last flag. Each beat carries one enable bit per byte lane. A lane is stored only when its enable bit is set, so a master can update part of a word while the other bytes keep their old contents.

After the final beat is accepted, the block waits a fixed number of clock cycles to model the time the storage needs to commit the data. It then raises one response carrying the original ID and a status. A burst that would reach past the end of the storage is still accepted beat by beat, but nothing is written and the status reports a decode error. Only one write is in flight at a time. An asynchronous read-only lookup port exposes the stored words so that the contents can be observed.

Top module: `bytelane_write_slave`

## Requirements
- R1: In reset and right after it, `aw_ready` is 1 and both `w_ready` and `b_valid` are 0.
- R2: Only one write is outstanding. `aw_ready` is 0 from the address handshake until the response handshake completes.
- R3: Byte lane i covers `w_data[8i+7:8i]` and `w_strb[i]`. On an accepted beat, lanes whose bit is 1 take the new byte and lanes whose bit is 0 keep their stored byte. An all-zero mask leaves the word unchanged.
- R4: The first beat of a burst goes to word index `aw_addr >> log2(DATA_W/8)`. The low byte-offset bits are dropped, which aligns the start. Each later beat goes to the next word index. `aw_len` is the beat count minus one.
- R5: `b_valid` rises exactly COMMIT_LAT clock edges after the edge that accepted the last beat. With COMMIT_LAT = 0 it rises on that same edge.
- R6: `b_id` equals the `aw_id` captured at the address handshake.
- R7: `b_resp` is 2'b00 (success) when every beat index is below DEPTH. It is 2'b11 (decode error) when the start index plus `aw_len` is DEPTH or more, and in that case no word is modified.
- R8: Once `b_valid` is 1, it stays 1 with `b_id` and `b_resp` unchanged until a cycle with `b_ready` = 1.
- R9: `w_ready` is 1 only after an address has been accepted and before its last beat. Beats offered while no address is pending are neither accepted nor stored.
- R10: `pk_word` returns, combinationally, the word stored at index `pk_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Address request valid |
| aw_ready | output | 1 | Address request accepted |
| aw_addr | input | ADDR_W | Byte start address |
| aw_id | input | ID_W | Transaction ID |
| aw_len | input | 8 | Beats in burst minus one |
| w_valid | input | 1 | Data beat valid |
| w_ready | output | 1 | Data beat accepted |
| w_data | input | DATA_W | Beat data |
| w_strb | input | DATA_W/8 | Per-byte write enables |
| w_last | input | 1 | Final beat of burst |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response taken |
| b_id | output | ID_W | ID of the completed write |
| b_resp | output | 2 | Status: 00 success, 11 decode error |
| pk_idx | input | log2(DEPTH) | Word index to observe |
| pk_word | output | DATA_W | Stored word at `pk_idx` |

## Verification
The bench builds the block with 32-bit data, 16 words of storage, a 12-bit address, 4-bit IDs and a commit latency of 3. A 16-word store lets one burst fill the whole array and lets a short burst starting near the top run past the end, so both response codes are reached. A latency of 3 keeps a multi-cycle commit window visible, during which `aw_ready` must stay low. Holding `b_ready` low for several cycles exercises the rule that the response is held steady, and the four-lane mask covers single, split, empty and top-lane patterns.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_COMMIT,
    ST_RESP
  } bws_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  // True when the last beat index of a burst falls outside the store.
  function automatic logic span_exceeds(input logic [31:0] first_word,
                                        input logic [31:0] beats_m1,
                                        input logic [31:0] depth);
    return (first_word + beats_m1) >= depth;
  endfunction

  function automatic logic [1:0] status_of(input logic decode_err);
    return decode_err ? RESP_DECERR : RESP_OKAY;
  endfunction

endpackage

// File: rtl/bws_commit_timer.sv
module bws_commit_timer #(
  parameter int COMMIT_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic fire
);

  generate
    if (COMMIT_LAT == 0) begin : g_zero
      assign fire = arm;
    end else begin : g_count
      localparam int CW = (COMMIT_LAT < 2) ? 1 : $clog2(COMMIT_LAT);
      logic [CW-1:0] cnt_q;
      logic          run_q;

      assign fire = run_q && (cnt_q == '0);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else if (arm) begin
          run_q <= 1'b1;
          cnt_q <= CW'(COMMIT_LAT - 1);
        end else if (run_q) begin
          if (cnt_q == '0) run_q <= 1'b0;
          else             cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bws_lane_mem.sv
module bws_lane_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_strb,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_q [DEPTH];

      always_ff @(posedge clk) begin
        if (wr_en && wr_strb[g]) lane_q[wr_idx] <= wr_data[8*g +: 8];
      end

      assign rd_data[8*g +: 8] = lane_q[rd_idx];
    end
  endgenerate

endmodule

// File: rtl/bws_ctrl.sv
module bws_ctrl
  import bws_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int ID_W       = 4,
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 16,
  localparam int LANE_BITS = $clog2(DATA_W / 8),
  localparam int PTR_W     = ADDR_W - LANE_BITS,
  localparam int IDX_W     = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [7:0]        aw_len,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  input  logic              commit_fire,
  output logic              last_beat_acc,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx
);

  bws_state_e       state_q, state_d;
  logic [ID_W-1:0]  id_q;
  logic [PTR_W-1:0] ptr_q;
  logic             err_q;
  logic             aw_acc;
  logic             beat_acc;

  assign aw_ready      = (state_q == ST_IDLE);
  assign w_ready       = (state_q == ST_DATA);
  assign b_valid       = (state_q == ST_RESP);
  assign aw_acc        = aw_valid && aw_ready;
  assign beat_acc      = w_valid && w_ready;
  assign last_beat_acc = beat_acc && w_last;
  assign wr_en         = beat_acc && !err_q;
  assign wr_idx        = ptr_q[IDX_W-1:0];
  assign b_id          = id_q;
  assign b_resp        = status_of(err_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (aw_acc) state_d = ST_DATA;
      ST_DATA:   if (last_beat_acc) state_d = commit_fire ? ST_RESP : ST_COMMIT;
      ST_COMMIT: if (commit_fire) state_d = ST_RESP;
      ST_RESP:   if (b_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
      ptr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (aw_acc) begin
        id_q  <= aw_id;
        ptr_q <= aw_addr[ADDR_W-1:LANE_BITS];
        err_q <= span_exceeds(32'(aw_addr[ADDR_W-1:LANE_BITS]), 32'(aw_len),
                              32'(DEPTH));
      end else if (beat_acc) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bytelane_write_slave.sv
module bytelane_write_slave #(
  parameter int ADDR_W     = 12,
  parameter int ID_W       = 4,
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 16,
  parameter int COMMIT_LAT = 3,
  localparam int LANES     = DATA_W / 8,
  localparam int IDX_W     = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [7:0]        aw_len,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [LANES-1:0]  w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  input  logic [IDX_W-1:0]  pk_idx,
  output logic [DATA_W-1:0] pk_word
);

  // Internal events named for the checker.
  logic             last_beat_acc;
  logic             commit_fire;
  logic             mem_wr_en;
  logic [IDX_W-1:0] mem_wr_idx;

  bws_ctrl #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_id(aw_id), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .commit_fire(commit_fire), .last_beat_acc(last_beat_acc),
    .wr_en(mem_wr_en), .wr_idx(mem_wr_idx)
  );

  bws_commit_timer #(.COMMIT_LAT(COMMIT_LAT)) timer_i (
    .clk(clk), .rst_n(rst_n), .arm(last_beat_acc), .fire(commit_fire)
  );

  bws_lane_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk(clk), .wr_en(mem_wr_en), .wr_idx(mem_wr_idx),
    .wr_data(w_data), .wr_strb(w_strb),
    .rd_idx(pk_idx), .rd_data(pk_word)
  );

endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int ID_W       = 4,
  parameter int COMMIT_LAT = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            aw_valid,
  input logic            aw_ready,
  input logic            w_ready,
  input logic            b_valid,
  input logic            b_ready,
  input logic [ID_W-1:0] b_id,
  input logic [1:0]      b_resp,
  input logic            last_beat_acc
);

  // Edges since the last accepted final beat, saturating.
  logic [15:0] since_last_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             since_last_q <= '0;
    else if (last_beat_acc) since_last_q <= '0;
    else if (since_last_q != 16'hFFFF) since_last_q <= since_last_q + 1'b1;
  end

  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid || w_ready) |-> !aw_ready);

  a_r5_commit_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> (since_last_q == 16'(COMMIT_LAT)));

  a_r7_resp_code: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> (b_resp == 2'b00 || b_resp == 2'b11));

  a_r8_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_id) && $stable(b_resp)));

  a_r9_data_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_ready) |-> $past(aw_valid && aw_ready));

endmodule

bind bytelane_write_slave bws_checker #(.ID_W(ID_W), .COMMIT_LAT(COMMIT_LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
  .w_ready(w_ready), .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
  .b_resp(b_resp), .last_beat_acc(last_beat_acc)
);

// File: tb/bytelane_write_slave_tb_top.sv
module bytelane_write_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int IW  = 4;
  localparam int DW  = 32;
  localparam int DEP = 16;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          aw_valid = 1'b0, w_valid = 1'b0, w_last = 1'b0, b_ready = 1'b0;
  logic [AW-1:0] aw_addr = '0;
  logic [IW-1:0] aw_id = '0;
  logic [7:0]    aw_len = '0;
  logic [DW-1:0] w_data = '0;
  logic [3:0]    w_strb = '0;
  logic [3:0]    pk_idx = '0;
  logic          aw_ready, w_ready, b_valid;
  logic [IW-1:0] b_id;
  logic [1:0]    b_resp;
  logic [DW-1:0] pk_word;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [31:0] exp_mem [DEP];
  logic [31:0] beat_d [16];
  logic [3:0]  beat_s [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bytelane_write_slave #(.ADDR_W(AW), .ID_W(IW), .DATA_W(DW), .DEPTH(DEP),
                         .COMMIT_LAT(LAT)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // R10 / R3: compare every stored word with the bench's own byte model.
  task automatic check_store(input string req);
    for (int w = 0; w < DEP; w++) begin
      pk_idx = 4'(w);
      #1;
      chk(pk_word === exp_mem[w], req, pk_word, exp_mem[w]);
    end
  endtask

  task automatic write_burst(input logic [IW-1:0] id, input int word, input int offs,
                             input int len, input int hold_b);
    int  last_c, t;
    bit  ok, err;
    logic [1:0] rsp;
    err = (word + len) >= DEP;              // R7 rule restated
    rsp = err ? 2'b11 : 2'b00;
    @(negedge clk);
    aw_valid = 1; aw_id = id; aw_addr = AW'(word * 4 + offs); aw_len = 8'(len);
    forever begin ok = aw_ready; @(negedge clk); if (ok) break; end
    aw_valid = 0;
    chk(aw_ready == 1'b0, "R2 aw_ready low in data phase", {31'd0, aw_ready}, 0);
    for (int b = 0; b <= len; b++) begin
      w_valid = 1; w_data = beat_d[b]; w_strb = beat_s[b]; w_last = (b == len);
      forever begin ok = w_ready; @(negedge clk); if (ok) break; end
      if (!err)                             // R4: word+b, R3: per-lane mask
        for (int l = 0; l < 4; l++)
          if (beat_s[b][l]) exp_mem[word + b][8*l +: 8] = beat_d[b][8*l +: 8];
    end
    last_c = cyc;
    w_valid = 0; w_last = 0;
    t = 0;
    while (!b_valid && t < 50) begin
      chk(aw_ready == 1'b0, "R2 aw_ready low in commit", {31'd0, aw_ready}, 0);
      @(negedge clk); t++;
    end
    chk(cyc - last_c == LAT, "R5 commit latency", cyc - last_c, LAT);
    chk(b_id == id, "R6 b_id echo", {28'd0, b_id}, {28'd0, id});
    chk(b_resp == rsp, "R7 b_resp", {30'd0, b_resp}, {30'd0, rsp});
    repeat (hold_b) begin
      @(negedge clk);
      chk(b_valid && b_id == id && b_resp == rsp, "R8 response held",
          {b_valid, 25'd0, b_resp, b_id}, {1'b1, 25'd0, rsp, id});
    end
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
    chk(!b_valid && aw_ready, "R2 free after response", {30'd0, b_valid, aw_ready}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(aw_ready && !w_ready && !b_valid, "R1 reset state",
        {29'd0, aw_ready, w_ready, b_valid}, 32'b100);
    rst_n = 1;
    @(negedge clk);
    chk(aw_ready && !w_ready && !b_valid, "R1 after reset",
        {29'd0, aw_ready, w_ready, b_valid}, 32'b100);

    // Fill the whole store with full masks (R3, R4).
    for (int i = 0; i < 16; i++) begin beat_d[i] = 32'hA5000000 + i * 32'h0101; beat_s[i] = 4'hF; end
    write_burst(4'd1, 0, 0, 15, 0);
    check_store("R3 R10 full-mask fill");

    // R9: beats without an address are not taken and not stored.
    w_valid = 1; w_data = 32'hFFFF_FFFF; w_strb = 4'hF; w_last = 1;
    repeat (3) begin
      @(negedge clk);
      chk(w_ready == 1'b0, "R9 no beat before address", {31'd0, w_ready}, 0);
    end
    w_valid = 0; w_last = 0;
    check_store("R9 store unchanged");

    // Partial masks, unaligned start at word 4 (offset 3 dropped): R3, R4.
    beat_d[0] = 32'h11223344; beat_s[0] = 4'b0001;
    beat_d[1] = 32'h55667788; beat_s[1] = 4'b0110;
    beat_d[2] = 32'h99AABBCC; beat_s[2] = 4'b0000;
    beat_d[3] = 32'hDDEEFF00; beat_s[3] = 4'b1000;
    write_burst(4'd5, 4, 3, 3, 2);
    check_store("R3 R4 partial masks");

    // Decode error: burst runs past the top, nothing written (R7).
    for (int i = 0; i < 4; i++) begin beat_d[i] = 32'hDEAD0000 + i; beat_s[i] = 4'hF; end
    write_burst(4'd9, 14, 0, 3, 1);
    check_store("R7 no write on decode error");
    write_burst(4'd12, 20, 0, 0, 0);
    check_store("R7 start beyond store");

    // Single beat at top word, response held under backpressure (R8).
    beat_d[0] = 32'h0BADF00D; beat_s[0] = 4'b0101;
    write_burst(4'd15, 15, 2, 0, 4);
    check_store("R3 R10 top word single beat");

    finish_run();
  end

endmodule